// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two words held in signed-magnitude form. Each word uses its top bit as the sign and the lower bits as an unsigned magnitude. The unit has no clock and no internal state, so its outputs follow its inputs within the same cycle. A datapath uses it wherever values are kept with a separate sign rather than in two's-complement form.

A subtract request flips the sign of the second operand, and the sum rules then apply. When the two effective signs agree, the magnitudes are added and the shared sign is kept. When the signs disagree, the second magnitude is taken from the first. If that subtraction ends with a borrow, the difference is replaced by its two's complement and the result takes the second operand's effective sign. A magnitude sum that no longer fits in the magnitude field raises the overflow flag. A zero result always carries a positive sign.

Top module: `sm_addsub`

## Requirements
- R1: Bit W-1 of every operand and of the result is the sign (0 positive, 1 negative), and bits W-2..0 hold the unsigned magnitude. With W=8, +9 is 00001001 and -9 is 10001001.
- R2: When the effective signs match, the result magnitude is the sum of the magnitudes and the result sign is the common sign (-5 + -3 gives 10001000).
- R3: When the effective signs match and the magnitude sum exceeds 2^(W-1)-1, ovf_o is 1 and the result magnitude is the sum modulo 2^(W-1) (+100 + +50 gives 00010110 with ovf_o=1).
- R4: When the effective signs differ and the first magnitude is at least the second, the result magnitude is their difference and the sign is the first operand's sign (+37 + -25 gives 00001100).
- R5: When the effective signs differ and the first magnitude is smaller, the result magnitude is second minus first and the sign is the second operand's effective sign (+25 + -37 gives 10001100).
- R6: With sub_i=1 the result equals the sum of op_a_i and op_b_i with op_b_i's sign bit inverted (+5 - +12 gives 10000111).
- R7: A result with zero magnitude always has sign 0. This holds for -0 + -0, for +9 - +9, and for an overflowing sum whose wrapped magnitude is zero.
- R8: ovf_o is 0 whenever the effective signs differ.
- R9: The outputs depend only on the present inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | W | First operand, signed-magnitude |
| op_b_i | input | W | Second operand, signed-magnitude |
| sub_i | input | 1 | 1 selects op_a_i - op_b_i, 0 selects op_a_i + op_b_i |
| res_o | output | W | Signed-magnitude result |
| ovf_o | output | 1 | Magnitude overflow flag |

## Verification
The embedded checks treat every input word as a legal operand, including both encodings of zero. They assume the inputs hold still while they are evaluated, because the unit has no clock to qualify them. The bench drives each stimulus once, shortly after a clock edge, and compares the outputs half a cycle later, so the inputs stay stable for the whole comparison. Directed cases cover both signs of zero, the borrow and no-borrow subtract paths, and a wrap to exactly zero. Uniformly drawn words then cover every combination of sign and operation.

// File: rtl/sm_arith_pkg.sv
package sm_arith_pkg;

    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } sgn_e;

    typedef enum logic [1:0] {
        PATH_ADD = 2'd0,
        PATH_FWD = 2'd1,
        PATH_REV = 2'd2
    } path_e;

    function automatic sgn_e eff_sign(input logic raw_sign, input logic negate);
        return sgn_e'(raw_sign ^ negate);
    endfunction

endpackage

// File: rtl/sm_field_split.sv
module sm_field_split #(
    parameter int W = 8,
    localparam int MW = W - 1
) (
    input  logic [W-1:0]        word_i,
    output sm_arith_pkg::sgn_e  sgn_o,
    output logic [MW-1:0]       mag_o
);
    assign sgn_o = sm_arith_pkg::sgn_e'(word_i[W-1]);
    assign mag_o = word_i[MW-1:0];
endmodule

// File: rtl/sm_mag_engine.sv
module sm_mag_engine #(
    parameter int MW = 7,
    localparam int EW = MW + 1
) (
    input  logic [MW-1:0]        mag_a_i,
    input  logic [MW-1:0]        mag_b_i,
    input  logic                 same_i,
    output logic [MW-1:0]        mag_o,
    output logic                 carry_o,
    output sm_arith_pkg::path_e  path_o
);
    import sm_arith_pkg::*;

    logic [EW-1:0] sum_x;
    logic [EW-1:0] dif_x;
    logic [MW-1:0] fixed;
    logic          borrow;

    assign sum_x  = {1'b0, mag_a_i} + {1'b0, mag_b_i};
    assign dif_x  = {1'b0, mag_a_i} - {1'b0, mag_b_i};
    assign borrow = dif_x[MW];
    assign fixed  = ~dif_x[MW-1:0] + {{(MW-1){1'b0}}, 1'b1};

    always_comb begin
        if (same_i)       path_o = PATH_ADD;
        else if (!borrow) path_o = PATH_FWD;
        else              path_o = PATH_REV;
    end

    always_comb begin
        unique case (path_o)
            PATH_ADD: mag_o = sum_x[MW-1:0];
            PATH_FWD: mag_o = dif_x[MW-1:0];
            default:  mag_o = fixed;
        endcase
    end

    assign carry_o = same_i & sum_x[MW];

    // R5: corrected magnitude matches a direct reverse subtraction
    always_comb begin
        if (path_o == PATH_REV) begin
            p_rev_mag_r5: assert (mag_o == MW'(mag_b_i - mag_a_i))
                else $error("p_rev_mag_r5");
        end
    end

    // R4: a forward difference never exceeds the first magnitude
    always_comb begin
        if (path_o == PATH_FWD) begin
            p_fwd_le_r4: assert (mag_o <= mag_a_i)
                else $error("p_fwd_le_r4");
        end
    end
endmodule

// File: rtl/sm_result_pack.sv
module sm_result_pack #(
    parameter int W = 8,
    localparam int MW = W - 1
) (
    input  sm_arith_pkg::sgn_e   sgn_a_i,
    input  sm_arith_pkg::sgn_e   sgn_b_i,
    input  sm_arith_pkg::path_e  path_i,
    input  logic [MW-1:0]        mag_i,
    input  logic                 carry_i,
    output logic [W-1:0]         word_o,
    output logic                 ovf_o
);
    import sm_arith_pkg::*;

    sgn_e sgn_pick;
    sgn_e sgn_fin;

    always_comb begin
        if (path_i == PATH_REV) sgn_pick = sgn_b_i;
        else                    sgn_pick = sgn_a_i;
        sgn_fin = (mag_i == '0) ? SGN_POS : sgn_pick;
    end

    assign word_o = {logic'(sgn_fin), mag_i};
    assign ovf_o  = carry_i;

    // R7: no negative zero leaves the unit
    always_comb begin
        if (word_o[MW-1:0] == '0) begin
            p_no_neg_zero_r7: assert (word_o[W-1] == 1'b0)
                else $error("p_no_neg_zero_r7");
        end
    end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
    parameter int W = 8,
    localparam int MW = W - 1
) (
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    import sm_arith_pkg::*;

    sgn_e          sgn_a;
    sgn_e          sgn_b_raw;
    sgn_e          sgn_b_eff;
    logic [MW-1:0] mag_a;
    logic [MW-1:0] mag_b;
    logic [MW-1:0] mag_r;
    logic          carry;
    logic          same;
    path_e         path;

    sm_field_split #(.W(W)) u_split_a (
        .word_i (op_a_i),
        .sgn_o  (sgn_a),
        .mag_o  (mag_a)
    );

    sm_field_split #(.W(W)) u_split_b (
        .word_i (op_b_i),
        .sgn_o  (sgn_b_raw),
        .mag_o  (mag_b)
    );

    assign sgn_b_eff = eff_sign(logic'(sgn_b_raw), sub_i);
    assign same      = (sgn_a == sgn_b_eff);

    sm_mag_engine #(.MW(MW)) u_engine (
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .same_i  (same),
        .mag_o   (mag_r),
        .carry_o (carry),
        .path_o  (path)
    );

    sm_result_pack #(.W(W)) u_pack (
        .sgn_a_i (sgn_a),
        .sgn_b_i (sgn_b_eff),
        .path_i  (path),
        .mag_i   (mag_r),
        .carry_i (carry),
        .word_o  (res_o),
        .ovf_o   (ovf_o)
    );

    // R8: overflow only with matching effective signs
    always_comb begin
        if (ovf_o) begin
            p_ovf_same_r8: assert (op_a_i[W-1] == (op_b_i[W-1] ^ sub_i))
                else $error("p_ovf_same_r8");
        end
    end

    // R2: a nonzero result of a same-sign operation keeps that sign
    always_comb begin
        if ((op_a_i[W-1] == (op_b_i[W-1] ^ sub_i)) && (res_o[MW-1:0] != '0)) begin
            p_sum_sign_r2: assert (res_o[W-1] == op_a_i[W-1])
                else $error("p_sum_sign_r2");
        end
    end
endmodule

// File: tb/sm_addsub_test.sv
module sm_addsub_test;
    localparam int W    = 8;
    localparam int MW   = W - 1;
    localparam int MAXM = (1 << MW) - 1;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         sub;
        logic [W-1:0] res;
        logic         ovf;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub  = 1'b0;
    logic [W-1:0] res;
    logic         ovf;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    sm_addsub #(.W(W)) uut (
        .op_a_i (op_a),
        .op_b_i (op_b),
        .sub_i  (sub),
        .res_o  (res),
        .ovf_o  (ovf)
    );

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic s, output logic [W-1:0] r,
                                  output logic v);
        int va, vb, t, m;
        va = a[W-1] ? -int'(a[MW-1:0]) : int'(a[MW-1:0]);
        vb = (b[W-1] ^ s) ? -int'(b[MW-1:0]) : int'(b[MW-1:0]);
        t  = va + vb;
        m  = (t < 0) ? -t : t;
        v  = (m > MAXM);
        m  = m % (MAXM + 1);
        r  = {(t < 0 && m != 0), MW'(m)};
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        op_a = a;
        op_b = b;
        sub  = s;
        it.a = a; it.b = b; it.sub = s; it.tag = tag;
        model(a, b, s, it.res, it.ovf);
        sb_q.push_back(it);
    endtask

    task automatic expect_lit(input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic s, input logic [W-1:0] er,
                              input logic ev, input string tag);
        logic [W-1:0] mr;
        logic         mv;
        model(a, b, s, mr, mv);
        n_chk++;
        if (mr !== er || mv !== ev) begin
            n_fail++;
            $display("FAIL %s model got %b/%b expected %b/%b", tag, mr, mv, er, ev);
        end
        drive(a, b, s, tag);
    endtask

    // monitor: compare half a cycle after each drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (res !== it.res || ovf !== it.ovf) begin
                n_fail++;
                $display("FAIL %s a=%b b=%b sub=%b actual res=%b ovf=%b expected res=%b ovf=%b",
                         it.tag, it.a, it.b, it.sub, res, ovf, it.res, it.ovf);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (res !== '0 || ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset-state actual %b/%b expected 00000000/0", res, ovf);
        end
        expect_lit(8'b00001001, 8'b10001001, 1'b1, 8'b00010010, 1'b0, "R1 +9 minus -9");
        expect_lit(8'b10000101, 8'b10000011, 1'b0, 8'b10001000, 1'b0, "R2 -5 plus -3");
        expect_lit(8'b00000101, 8'b00000011, 1'b0, 8'b00001000, 1'b0, "R2 +5 plus +3");
        expect_lit(8'b01100100, 8'b00110010, 1'b0, 8'b00010110, 1'b1, "R3 +100 plus +50");
        expect_lit(8'b11100100, 8'b10110010, 1'b0, 8'b10010110, 1'b1, "R3 -100 plus -50");
        expect_lit(8'b01111111, 8'b01111111, 1'b0, 8'b01111110, 1'b1, "R3 max plus max");
        expect_lit(8'b00100101, 8'b10011001, 1'b0, 8'b00001100, 1'b0, "R4 +37 plus -25");
        expect_lit(8'b00011001, 8'b10100101, 1'b0, 8'b10001100, 1'b0, "R5 +25 plus -37");
        expect_lit(8'b00000101, 8'b00001100, 1'b1, 8'b10000111, 1'b0, "R6 +5 minus +12");
        expect_lit(8'b10001001, 8'b00001001, 1'b1, 8'b10010010, 1'b0, "R6 -9 minus +9");
        expect_lit(8'b00001001, 8'b00001001, 1'b1, 8'b00000000, 1'b0, "R7 +9 minus +9");
        expect_lit(8'b10000000, 8'b10000000, 1'b0, 8'b00000000, 1'b0, "R7 -0 plus -0");
        expect_lit(8'b01000000, 8'b01000000, 1'b0, 8'b00000000, 1'b1, "R7 wrap to zero");
        expect_lit(8'b11111111, 8'b01111111, 1'b0, 8'b00000000, 1'b0, "R8 -127 plus +127");
        expect_lit(8'b01111111, 8'b01111111, 1'b1, 8'b00000000, 1'b0, "R8 +127 minus +127");
        for (int i = 0; i < 3000; i++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), "R9 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule